// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Stall-and-Replay Refill

This block sits between a processor load port and a slower main-memory read port. It holds one data word per line in a direct-mapped array. Each request carries a byte address. The low bits select a byte within the word and take no part in the lookup. The middle bits pick a line. The upper bits are compared with the tag stored in that line. A lookup that finds a valid line with a matching tag returns the word in the same cycle.

A lookup that misses does not return data. From the next cycle on, the block holds the processor with `stall`. It then reads the word-aligned address from memory over a req/ack handshake, and the memory may take one or more cycles to answer. When the answer arrives, the block writes the returned word, the tag and the valid bit into the line. In the following cycle it repeats the same lookup, which now hits and returns the word. `stall` drops one cycle after that.

The processor side is a request stream with `req_valid` and `req_addr`. The block accepts a request only in a cycle where `stall` is low, so `!stall` acts as the ready signal. While `stall` is high the processor must hold `req_valid` and `req_addr` unchanged. Responses have no back-pressure: `rsp_valid` is a one-cycle pulse.

Top module: `cdm_cache`

## Requirements
- R1: After reset every valid bit is clear. `stall`, `mem_req` and `rsp_valid` are low, and the first access to any line is a miss.
- R2: A lookup hits only if the selected line is valid and its stored tag equals address bits [31:IDX_W+2]. A different tag at the same line misses, and its refill replaces the old contents.
- R3: On a hit, `rsp_valid` is high and `rsp_data` holds the line's word in the cycle the request is presented, with `stall` low. Address bits [1:0] have no effect on which word is returned.
- R4: On a miss, `rsp_valid` is low in the request cycle. `stall` is high from the next cycle until the replay completes.
- R5: During a miss, `mem_req` is high with `mem_addr` equal to the request address with bits [1:0] cleared. Both stay stable until `mem_ack`, and each miss makes exactly one memory read.
- R6: The word presented with `mem_ack` is written into the line together with the tag and valid bit. In the next cycle the replayed lookup hits, and `rsp_valid` is high with that word while `stall` is still high. `stall` is low in the cycle after that.
- R7: With `req_valid` low and `stall` low, the block issues no memory request and gives no response. A request is taken only in a cycle with `stall` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_addr | input | ADDR_W | Processor byte address |
| stall | output | 1 | Processor hold; request taken only when low |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_data | output | DATA_W | Read data word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Word-aligned memory read address |
| mem_ack | input | 1 | Memory read data present |
| mem_data | input | DATA_W | Memory read data |

## Verification
The assertions assume that the processor holds `req_valid` and `req_addr` steady while `stall` is high. They also assume that memory raises `mem_ack` only while `mem_req` is high and keeps `mem_data` valid in that cycle. The bench changes processor inputs only at falling edges that follow a response or fall in an idle cycle. Its memory model answers only requests it has seen and rotates its latency through one to four cycles. The sweeps run over a 16-line configuration and cover cold misses, hits with every byte offset, tag conflicts at each line, and a tag that differs only in its top bit.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  typedef enum logic [1:0] {
    CDM_IDLE   = 2'd0,
    CDM_MISS   = 2'd1,
    CDM_REPLAY = 2'd2
  } cdm_state_e;
endpackage

// File: rtl/cdm_line_store.sv
module cdm_line_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_data = data_q[rd_idx];
  end

  // R6: a filled line is valid and carries the written tag afterwards
  a_r6_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
               && data_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/cdm_refill_ctrl.sv
module cdm_refill_ctrl
  import cdm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 10,
  localparam int WORD_W = ADDR_W - OFF_W,
  localparam int TAG_W  = WORD_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] req_word,
  input  logic              hit,
  input  logic              mem_ack,
  output logic              stall,
  output logic              rsp_valid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              fill_en
);
  cdm_state_e        state_q;
  logic [WORD_W-1:0] cap_q;
  logic [WORD_W-1:0] lk_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CDM_IDLE;
      cap_q   <= '0;
    end else begin
      case (state_q)
        CDM_IDLE: if (req_valid && !hit) begin
          state_q <= CDM_MISS;
          cap_q   <= req_word;
        end
        CDM_MISS:   if (mem_ack) state_q <= CDM_REPLAY;
        CDM_REPLAY: state_q <= CDM_IDLE;
        default:    state_q <= CDM_IDLE;
      endcase
    end
  end

  always_comb begin
    stall     = (state_q != CDM_IDLE);
    mem_req   = (state_q == CDM_MISS);
    mem_addr  = {cap_q, {OFF_W{1'b0}}};
    lk_word   = stall ? cap_q : req_word;
    lk_idx    = lk_word[IDX_W-1:0];
    lk_tag    = lk_word[WORD_W-1:IDX_W];
    fill_en   = mem_req && mem_ack;
    rsp_valid = hit && ((state_q == CDM_IDLE && req_valid) || state_q == CDM_REPLAY);
  end

  // R5: request and address held until acknowledged
  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R6: the replayed lookup always hits
  a_r6_replay_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CDM_REPLAY) |-> hit);
  // R6: an acknowledged read is followed by a stalled response
  a_r6_ack_to_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (stall && rsp_valid));
  // R7: no memory traffic while the processor is free
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> !mem_req);
  // R4: stall only starts after a presented request that missed
  a_r4_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> ($past(req_valid) && !$past(rsp_valid)));
endmodule

// File: rtl/cdm_cache.sv
module cdm_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              stall,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int WORD_W = ADDR_W - OFF_W;
  localparam int TAG_W  = WORD_W - IDX_W;

  logic              hit;
  logic              fill_en;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              unused_off;

  assign unused_off = ^req_addr[OFF_W-1:0];

  cdm_refill_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_word(req_addr[ADDR_W-1:OFF_W]),
    .hit(hit), .mem_ack(mem_ack),
    .stall(stall), .rsp_valid(rsp_valid),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .fill_en(fill_en)
  );

  cdm_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_tag(lk_tag), .hit(hit), .rd_data(rsp_data),
    .wr_en(fill_en), .wr_idx(lk_idx), .wr_tag(lk_tag), .wr_data(mem_data)
  );

  // R3: a response never coincides with a memory request
  a_r3_no_rsp_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req);
endmodule

// File: tb/sim_cdm_cache.sv
module sim_cdm_cache;
  localparam int CLK_P = 10;
  localparam int IDX_W = 4;
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = 32 - IDX_W - 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic        stall, rsp_valid, mem_req, mem_ack;
  logic [31:0] rsp_data, mem_addr, mem_data;

  int errors = 0, checks = 0, reads = 0;
  int lat_target = 0, lat_cnt = 0;
  bit done = 0;
  bit             ref_v   [LINES];
  logic [TAG_W-1:0] ref_tag [LINES];

  always #(CLK_P/2) clk = ~clk;

  cdm_cache #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .stall(stall), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ((a & ~32'h3) * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic logic [31:0] mk(input int tg, input int idx, input int off);
    return (32'(tg) << (IDX_W + 2)) | (32'(idx) << 2) | 32'(off);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: latency rotates 1..4 cycles
  initial begin
    mem_ack = 0; mem_data = 0;
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req) begin
        if (lat_cnt == lat_target) begin
          mem_ack = 1; mem_data = mem_word(mem_addr); reads++;
          lat_cnt = 0; lat_target = (lat_target + 1) % 4;
        end else lat_cnt++;
      end
    end
  end

  task automatic do_access(input logic [31:0] a, input string lbl);
    int idx, n, r0;
    logic [TAG_W-1:0] tg;
    bit exp_hit, stall_ok, addr_ok;
    idx = int'((a >> 2) % LINES);
    tg  = TAG_W'(a >> (IDX_W + 2));
    exp_hit = ref_v[idx] && ref_tag[idx] == tg;
    r0 = reads;
    @(negedge clk); req_valid = 1; req_addr = a; #1;
    if (exp_hit) begin
      check(rsp_valid === 1 && stall === 0, {lbl, " hit response"}, {30'd0, stall, rsp_valid}, 32'd1);
      check(rsp_data === mem_word(a), {lbl, " hit data"}, rsp_data, mem_word(a));
    end else begin
      check(rsp_valid === 0, {lbl, " miss no response (R4)"}, {31'd0, rsp_valid}, 32'd0);
      stall_ok = 1; addr_ok = 1; n = 0;
      do begin
        @(negedge clk); #1; n++;
        if (stall !== 1) stall_ok = 0;
        if (mem_req && mem_addr !== (a & ~32'h3)) addr_ok = 0;
      end while (!rsp_valid && n < 20);
      check(stall_ok, "R4 stall held through miss", {31'd0, stall_ok}, 32'd1);
      check(addr_ok, "R5 word address", mem_addr, a & ~32'h3);
      check(reads - r0 == 1, "R5 one read per miss", 32'(reads - r0), 32'd1);
      check(rsp_valid === 1 && stall === 1, "R6 replay response", {30'd0, stall, rsp_valid}, 32'd3);
      check(rsp_data === mem_word(a), "R6 replay data", rsp_data, mem_word(a));
      ref_v[idx] = 1; ref_tag[idx] = tg;
      @(negedge clk); req_valid = 0; #1;
      check(stall === 0 && rsp_valid === 0, "R6 stall released", {30'd0, stall, rsp_valid}, 32'd0);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin ref_v[i] = 0; ref_tag[i] = '0; end
    repeat (3) @(negedge clk);
    check(stall === 0 && mem_req === 0 && rsp_valid === 0, "R1 reset outputs",
          {29'd0, stall, mem_req, rsp_valid}, 32'd0);
    rst_n = 1;
    // R1: cold sweep, every line misses
    for (int i = 0; i < LINES; i++) do_access(mk(5, i, 0), "R1");
    // R3: every line hits, all byte offsets
    for (int i = 0; i < LINES; i++)
      for (int o = 0; o < 4; o++) do_access(mk(5, i, o), "R3");
    // R2: conflicting tag on even lines, then original tag
    for (int i = 0; i < LINES; i += 2) do_access(mk(9, i, 1), "R2");
    for (int i = 0; i < LINES; i++) do_access(mk(5, i, 2), "R2");
    // R2: tag differing only in its top bit
    do_access(32'h8000_0000 | mk(5, 3, 0), "R2");
    do_access(mk(5, 3, 0), "R2");
    // mixed sweep over a few tags
    for (int k = 0; k < 96; k++) do_access(mk((k * 7) % 3, (k * 5) % LINES, k % 4), "R2");
    // R7: idle cycles give nothing
    begin
      int r0;
      r0 = reads;
      @(negedge clk); req_valid = 0;
      repeat (5) begin
        @(negedge clk); #1;
        check(mem_req === 0 && rsp_valid === 0 && stall === 0, "R7 idle quiet",
              {29'd0, stall, mem_req, rsp_valid}, 32'd0);
      end
      check(reads == r0, "R7 no reads when idle", 32'(reads), 32'(r0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule